// File: doc/BRIEF.md
# Short SPI Flash Command Engine

This block is an SPI master that runs one short serial-flash transaction each time software strobes it. A byte-wide host port with eight registers fronts the block. Software first loads an opcode, up to three address bytes and one optional data byte into the byte registers. It then writes a control byte that starts the transaction. That byte picks the bus speed, a 2-bit code for how many bytes go out, and how many bytes (0 to 3) come back.

The engine drives the serial clock, the MOSI line and an active-low chip select, and holds the busy flag up while it works. After the outgoing bytes it clocks out zero bytes and stores the returned bytes in the upper registers. Software polls the busy flag and then reads the result.

A second start code opens a page-program session. The opcode goes out, and chip select stays low while bytes arrive one at a time on a separate write-stream port. A control write of zero closes the session.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, register 0 reads 0x00, and registers 1 to 7 read 0x00.
- R2: A write to register 0 whose upper nibble is 0x4 or 0x5 starts a transaction. Bits [3:2] give the read count (0 to 3) and bits [1:0] give the write code. Writes to register 0 with any other upper nibble, except 0x2, 0x3 and a full 0x00, start nothing.
- R3: The write code sets the outgoing bytes and their order. Code 0 sends register 1. Code 1 sends register 1, then register 7. Code 2 sends registers 1, 4, 3, 2. Code 3 sends registers 1, 4, 3, 2, 7.
- R4: For each byte to be read, the engine shifts out 0x00 and stores the received byte. The first received byte goes to register 5, the second to register 6 and the third to register 7.
- R5: The bus runs in SPI mode 0 with MSB first. The serial clock idles low, MISO is sampled on the rising edge, and MOSI changes only while the serial clock is low.
- R6: Chip select goes low when a transaction starts and stays low between its bytes. It returns high only after the last bit, or when a page-program session is closed.
- R7: Bit 7 of register 0 reads 1 while a transaction or a page-program byte is being shifted. It reads 0 otherwise.
- R8: Upper nibble 0x5 gives a serial-clock period of 2*FAST_HALF system clocks. Upper nibble 0x4 gives 2*SLOW_HALF system clocks.
- R9: While a transaction is in progress, writes to any register, including new start writes, are ignored.
- R10: Upper nibble 0x2 or 0x3 in a register-0 write starts a page-program session. Register 1 is sent first, then each stream write is sent as one byte, and chip select stays low between bytes. A write of 0x00 to register 0, made when no byte is shifting, raises chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset for host read and write |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr (combinational) |
| stream_wr | input | 1 | Page-program byte strobe |
| stream_data | input | 8 | Page-program byte |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions check the bus rules on every cycle. The serial clock is low whenever chip select is high, and MOSI holds steady while the clock is high. Chip select rises only after a finished byte or a session-close write. The opcode register does not change under a running transaction, and divider ticks are never back to back. Only the bench scenarios can show the rest. These are the byte order for each write code, where the read bytes land, the actual clock period at each speed, and that a second start during busy adds no bytes. The page-program session, with chip select held low across bytes that arrive far apart, is also shown only by the scenarios.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PP_SHIFT,
        ST_PP_WAIT
    } eng_state_e;

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_OPCODE = 3'd1;
    localparam logic [2:0] OFS_RESP0  = 3'd5;

    // Outgoing byte count for each 2-bit write code
    function automatic logic [2:0] wr_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    // Byte to place on the wire at position pos of the outgoing phase
    function automatic logic [7:0] wire_byte(input logic [3:0] pos,
                                             input logic [1:0] code,
                                             input logic [7:0][7:0] rf);
        case (pos)
            4'd0:    return rf[1];
            4'd1:    return (code == 2'd1) ? rf[7] : rf[4];
            4'd2:    return rf[3];
            4'd3:    return rf[2];
            default: return rf[7];
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_divider.sv
module spi_cmd_divider #(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int MAXH = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int CW   = $clog2(MAXH + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
        tick  = en && (cnt_q == lim);
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && FAST_HALF > 1 && SLOW_HALF > 1) |=> !tick); // R8

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       active,
    output logic       done,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic       active;
        logic       sck;
        logic [2:0] bitcnt;
        logic [7:0] sh;
        logic [7:0] rx;
    } shf_s;

    shf_s d, q;

    always_comb begin
        d    = q;
        done = q.active && tick && q.sck && (q.bitcnt == 3'd7);
        if (q.active && tick) begin
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso};
            end else begin
                d.sck    = 1'b0;
                d.sh     = {q.sh[6:0], 1'b0};
                d.bitcnt = q.bitcnt + 3'd1;
                if (q.bitcnt == 3'd7) d.active = 1'b0;
            end
        end
        if (start) begin
            d.active = 1'b1;
            d.sck    = 1'b0;
            d.bitcnt = '0;
            d.sh     = tx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = q.sh[7];
    assign active  = q.active;
    assign rx_byte = q.rx;

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R5

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       stream_wr,
    input  logic [7:0] stream_data,
    output logic       spi_sck,
    output logic       spi_mosi,
    output logic       spi_cs_n,
    input  logic       spi_miso
);
    typedef struct packed {
        eng_state_e       state;
        logic             fast;
        logic [1:0]       wcode;
        logic [1:0]       rcnt;
        logic [3:0]       pos;
        logic [7:0][7:0]  rf;
    } eng_s;

    eng_s d, q;

    logic       sh_start, sh_done, sh_active, tick;
    logic [7:0] sh_tx, sh_rx;
    logic [3:0] wlen, total;
    logic [2:0] slot;
    logic       busy, ctrl_wr;

    spi_cmd_divider #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .en(sh_active), .fast(q.fast), .tick(tick)
    );

    spi_cmd_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
        .tick(tick), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .active(sh_active), .done(sh_done), .rx_byte(sh_rx)
    );

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        sh_tx    = '0;
        ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
        wlen     = {1'b0, wr_bytes(q.wcode)};
        total    = wlen + {2'b00, q.rcnt};
        slot     = 3'(q.pos - wlen) + OFS_RESP0;
        case (q.state)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    if (reg_wdata[7:5] == 3'b010) begin
                        d.fast   = reg_wdata[4];
                        d.rcnt   = reg_wdata[3:2];
                        d.wcode  = reg_wdata[1:0];
                        d.pos    = '0;
                        d.state  = ST_XFER;
                        sh_start = 1'b1;
                        sh_tx    = q.rf[OFS_OPCODE];
                    end else if (reg_wdata[7:5] == 3'b001) begin
                        d.fast   = reg_wdata[4];
                        d.state  = ST_PP_SHIFT;
                        sh_start = 1'b1;
                        sh_tx    = q.rf[OFS_OPCODE];
                    end
                end else if (reg_wr) begin
                    d.rf[reg_addr] = reg_wdata;
                end
            end
            ST_XFER: begin
                if (sh_done) begin
                    if (q.pos >= wlen) d.rf[slot] = sh_rx;
                    if (q.pos + 4'd1 == total) begin
                        d.state = ST_IDLE;
                    end else begin
                        d.pos    = q.pos + 4'd1;
                        sh_start = 1'b1;
                        sh_tx    = (q.pos + 4'd1 < wlen) ?
                                   wire_byte(q.pos + 4'd1, q.wcode, q.rf) : 8'h00;
                    end
                end
            end
            ST_PP_SHIFT: begin
                if (sh_done) d.state = ST_PP_WAIT;
            end
            default: begin
                if (ctrl_wr && reg_wdata == 8'h00) begin
                    d.state = ST_IDLE;
                end else if (stream_wr) begin
                    d.state  = ST_PP_SHIFT;
                    sh_start = 1'b1;
                    sh_tx    = stream_data;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state == ST_XFER) || (q.state == ST_PP_SHIFT);
    assign spi_cs_n  = (q.state == ST_IDLE);
    assign reg_rdata = (reg_addr == OFS_CTRL) ? {busy, 7'h00} : q.rf[reg_addr];

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R5

    AST_CS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> ($past(sh_done) ||
                             $past(reg_wr && reg_addr == 3'd0 && reg_wdata == 8'h00))); // R6

    AST_OPCODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_XFER && reg_wr && reg_addr == OFS_OPCODE) |=> $stable(q.rf[1])); // R9

    AST_BUSY_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && !$past(spi_cs_n) && q.state == ST_PP_SHIFT) |-> $past(stream_wr)); // R10

endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
    localparam int FH = 2;
    localparam int SH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       stream_wr = 1'b0;
    logic [7:0] stream_data = '0;
    logic       spi_sck, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    spi_cmd_engine #(.FAST_HALF(FH), .SLOW_HALF(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stream_wr(stream_wr),
        .stream_data(stream_data), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // Slave model and monitor, all on the falling system-clock edge
    logic       prev_sck = 1'b0, prev_cs = 1'b1;
    int         bitpos = 0;
    logic [7:0] slv_base = 8'h00;
    logic [7:0] rx_sh = '0;
    int         rx_n = 0;
    int         last_rise = 0;
    int         period = 0;

    function automatic logic [7:0] slv_byte(int k);
        return slv_base + 8'(k * 8'h11);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin
            bitpos = 0;
            rx_n   = 0;
        end
        if (!spi_cs_n && prev_sck && !spi_sck) bitpos++;
        spi_miso <= slv_byte(bitpos / 8)[7 - (bitpos % 8)];
        if (!spi_cs_n && spi_sck && !prev_sck) begin
            if (last_rise != 0) period = cyc - last_rise;
            last_rise = cyc;
            rx_sh = {rx_sh[6:0], spi_mosi};
            rx_n++;
            if (rx_n == 8) begin
                rx_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", rx_sh, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    check(rx_sh == e, t, rx_sh, e);
                end
            end
        end
        if (spi_cs_n) last_rise = 0;
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_cs_high();
        while (!spi_cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_not_busy();
        logic [7:0] v;
        rd(3'd0, v);
        while (v[7]) rd(3'd0, v);
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n === 1'b1, "R1", spi_cs_n, 1);
        check(spi_sck === 1'b0, "R1", spi_sck, 0);
        rd(3'd0, v); check(v === 8'h00, "R1", v, 0);
        rd(3'd6, v); check(v === 8'h00, "R1", v, 0);

        // R3 code 0, slow clock, R8 period
        wr(3'd1, 8'h06);
        push(8'h06, "R3");
        wr(3'd0, 8'h40);
        rd(3'd0, v); check(v === 8'h80, "R7", v, 8'h80);
        check(spi_cs_n === 1'b0, "R6", spi_cs_n, 0);
        wait_cs_high();
        check(period == 2 * SH, "R8", period, 2 * SH);
        rd(3'd0, v); check(v === 8'h00, "R7", v, 0);

        // R3 code 1, fast clock
        wr(3'd7, 8'hC3);
        push(8'h06, "R3"); push(8'hC3, "R3");
        wr(3'd0, 8'h51);
        wait_cs_high();
        check(period == 2 * FH, "R8", period, 2 * FH);

        // R3 code 2 with three reads (R4)
        slv_base = 8'h20;
        wr(3'd1, 8'h03); wr(3'd4, 8'h12); wr(3'd3, 8'h34); wr(3'd2, 8'h56);
        push(8'h03, "R3"); push(8'h12, "R3"); push(8'h34, "R3"); push(8'h56, "R3");
        push(8'h00, "R4"); push(8'h00, "R4"); push(8'h00, "R4");
        wr(3'd0, 8'h5E);
        wait_cs_high();
        rd(3'd5, v); check(v === slv_byte(4), "R4", v, slv_byte(4));
        rd(3'd6, v); check(v === slv_byte(5), "R4", v, slv_byte(5));
        rd(3'd7, v); check(v === slv_byte(6), "R4", v, slv_byte(6));

        // R3 code 3, then R9 writes during busy ignored
        wr(3'd7, 8'h9A);
        push(8'h03, "R3"); push(8'h12, "R3"); push(8'h34, "R3"); push(8'h56, "R3");
        push(8'h9A, "R3");
        wr(3'd0, 8'h53);
        wr(3'd1, 8'hEE);
        wr(3'd0, 8'h40);
        wait_cs_high();
        rd(3'd1, v); check(v === 8'h03, "R9", v, 8'h03);

        // R4 code 0 with two reads, R5 MSB-first sampling
        slv_base = 8'hB1;
        wr(3'd1, 8'h05);
        push(8'h05, "R5"); push(8'h00, "R4"); push(8'h00, "R4");
        wr(3'd0, 8'h58);
        wait_cs_high();
        rd(3'd5, v); check(v === slv_byte(1), "R5", v, slv_byte(1));
        rd(3'd6, v); check(v === slv_byte(2), "R4", v, slv_byte(2));

        // R2 undefined nibble starts nothing
        wr(3'd0, 8'h70);
        repeat (4) @(negedge clk);
        check(spi_cs_n === 1'b1, "R2", spi_cs_n, 1);
        rd(3'd0, v); check(v === 8'h00, "R2", v, 0);

        // R10 page-program session
        wr(3'd1, 8'h02);
        push(8'h02, "R10");
        wr(3'd0, 8'h30);
        wait_not_busy();
        repeat (5) @(negedge clk);
        check(spi_cs_n === 1'b0, "R10", spi_cs_n, 0);
        push(8'hA5, "R10");
        @(negedge clk); stream_data = 8'hA5; stream_wr = 1'b1;
        @(negedge clk); stream_wr = 1'b0;
        wait_not_busy();
        push(8'h5A, "R10");
        @(negedge clk); stream_data = 8'h5A; stream_wr = 1'b1;
        @(negedge clk); stream_wr = 1'b0;
        wait_not_busy();
        check(spi_cs_n === 1'b0, "R6", spi_cs_n, 0);
        wr(3'd0, 8'h00);
        @(negedge clk);
        check(spi_cs_n === 1'b1, "R10", spi_cs_n, 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule